// File: doc/BRIEF.md
# Multiplexed Address/Data Register Port

This block is a byte-wide slave port that gives an external controller access to a small bank of internal registers. Address and data share one bus. The master first presents a register address and strobes an address-latch line. It then runs a read or a write cycle, which is qualified by active-low select, read and write strobes. All strobes, and the bus value, are brought into the internal clock domain through a flop chain. Every decision is taken on edges seen in that domain.

A write commits the bus value when the write strobe returns high. For a read, the block drives the addressed register onto the bus through an output enable. The enable is raised only while select and read are both low. The block also issues a one-cycle write pulse and a one-cycle read-end event so that neighbouring logic can act on register accesses, for example clear-on-read status. Every register value is available to the rest of the chip on a flat vector.

Top module: `abus_reg_slave`

## Requirements
- R1: After reset, every register reads zero, `bus_oe` is low, `bus_out` is zero, and neither `wr_pulse` nor `rd_event` is asserted.
- R2: The register address is the bus value present when `ale` falls from 1 to 0. Later bus changes do not alter it until the next such fall.
- R3: A write commits the bus value present when `wr_n` rises while `cs_n` is low. Values driven earlier in the same write strobe are discarded.
- R4: A `wr_n` pulse while `cs_n` is high changes no register and produces no `wr_pulse`.
- R5: `bus_oe` is high only while `cs_n` and `rd_n` are both low, after the synchronizer delay. While `bus_oe` is low, `bus_out` is zero.
- R6: While `bus_oe` is high, `bus_out` carries the value of the register at the latched address.
- R7: Writes to addresses at or above `NUM_REGS` are ignored and produce no `wr_pulse`. Reads from those addresses return zero.
- R8: Each committed write raises `wr_pulse` for exactly one clock cycle. During that cycle `wr_addr` and `wr_data` hold the address and value written.
- R9: When `rd_n` rises while `cs_n` is low, `rd_event` is high for exactly one clock cycle with `rd_addr` equal to the latched address. This applies to any address.
- R10: `regs_flat[r*DW +: DW]` holds the current value of register r.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ale | input | 1 | Address latch strobe, active high; the address is captured on its fall |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low; the write commits on its rise |
| bus_in | input | DW | Value seen on the shared address/data bus |
| bus_out | output | DW | Read data to drive onto the bus |
| bus_oe | output | 1 | Bus output enable for the pad driver |
| wr_pulse | output | 1 | One-cycle pulse per committed write |
| wr_addr | output | DW | Address of the committed write |
| wr_data | output | DW | Value of the committed write |
| rd_event | output | 1 | One-cycle pulse at the end of a read cycle |
| rd_addr | output | DW | Address of the read that ended |
| regs_flat | output | NUM_REGS*DW | All register values, register r at bits r*DW upward |

## Verification
The bench builds the block with an 8-bit bus, two synchronizer stages and `NUM_REGS` set to 6. Because 6 is not a power of two, addresses 6, 7 and 0xFF are unimplemented while sharing the decode width of the implemented ones. This exercises the range check on both the write side and the read side. The two-stage chain sets the latency that each directed cycle waits out before it samples. Late bus changes inside a write strobe, bus changes after the address fall, and strobes without select can therefore each be placed on a known side of the edges the block detects.

// File: rtl/abus_pkg.sv
package abus_pkg;

  // Sampled strobe set, ordered as carried through the synchronizer.
  typedef struct packed {
    logic ale;
    logic cs_n;
    logic rd_n;
    logic wr_n;
  } strobe_t;

  localparam strobe_t STROBE_IDLE = '{ale: 1'b0, cs_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1};

  typedef struct packed {
    logic ale_fall;
    logic wr_rise;
    logic rd_rise;
  } edge_t;

  function automatic edge_t find_edges(input strobe_t prev, input strobe_t cur);
    edge_t e;
    e.ale_fall = prev.ale & ~cur.ale;
    e.wr_rise  = ~prev.wr_n & cur.wr_n;
    e.rd_rise  = ~prev.rd_n & cur.rd_n;
    return e;
  endfunction

endpackage

// File: rtl/abus_sync.sv
module abus_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] ff_q;
    logic [W-1:0] ff_d;
    if (s == 0) begin : g_first
      assign ff_d = d;
    end else begin : g_next
      assign ff_d = g_stage[s-1].ff_q;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff_q <= RST_VAL;
      else        ff_q <= ff_d;
    end
  end

  assign q = g_stage[STAGES-1].ff_q;

endmodule

// File: rtl/abus_cycle_ctl.sv
module abus_cycle_ctl
  import abus_pkg::*;
#(
  parameter int DW = 8,
  parameter int NUM_REGS = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  strobe_t       strb,
  input  logic [DW-1:0] bus_d,
  output logic [DW-1:0] addr_q,
  output logic          wr_commit,
  output logic          rd_done,
  output logic          rd_live
);

  localparam logic [DW:0] ADDR_LIMIT = (DW+1)'(NUM_REGS);

  strobe_t       prev_q;
  strobe_t       prev_d;
  logic [DW-1:0] addr_d;
  logic          addr_ok;
  edge_t         edges;

  always_comb begin
    edges   = find_edges(prev_q, strb);
    prev_d  = strb;
    addr_d  = edges.ale_fall ? bus_d : addr_q;
    addr_ok = ({1'b0, addr_q} < ADDR_LIMIT);
    wr_commit = edges.wr_rise & ~strb.cs_n & addr_ok;
    rd_done   = edges.rd_rise & ~strb.cs_n;
    rd_live   = ~strb.cs_n & ~strb.rd_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= STROBE_IDLE;
      addr_q <= '0;
    end else begin
      prev_q <= prev_d;
      addr_q <= addr_d;
    end
  end

endmodule

// File: rtl/abus_regfile.sv
module abus_regfile #(
  parameter int DW = 8,
  parameter int NUM_REGS = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [DW-1:0]          waddr,
  input  logic [DW-1:0]          wdata,
  input  logic [DW-1:0]          raddr,
  output logic [DW-1:0]          rdata,
  output logic [NUM_REGS*DW-1:0] regs_flat
);

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_slot
    localparam logic [DW-1:0] IDX = DW'(r);
    logic [DW-1:0] q;
    logic [DW-1:0] q_next;
    logic          hit;

    always_comb begin
      hit    = we && (waddr == IDX);
      q_next = hit ? wdata : q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= q_next;
    end

    assign regs_flat[r*DW +: DW] = q;
  end

  // Unmatched addresses fall through to zero.
  always_comb begin
    rdata = '0;
    for (int r = 0; r < NUM_REGS; r++) begin
      if (raddr == DW'(r)) rdata = regs_flat[r*DW +: DW];
    end
  end

endmodule

// File: rtl/abus_reg_slave.sv
module abus_reg_slave
  import abus_pkg::*;
#(
  parameter int DW = 8,
  parameter int NUM_REGS = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ale,
  input  logic                   cs_n,
  input  logic                   rd_n,
  input  logic                   wr_n,
  input  logic [DW-1:0]          bus_in,
  output logic [DW-1:0]          bus_out,
  output logic                   bus_oe,
  output logic                   wr_pulse,
  output logic [DW-1:0]          wr_addr,
  output logic [DW-1:0]          wr_data,
  output logic                   rd_event,
  output logic [DW-1:0]          rd_addr,
  output logic [NUM_REGS*DW-1:0] regs_flat
);

  localparam int STRB_W = $bits(strobe_t);

  strobe_t       strb_raw;
  strobe_t       strb_s;
  logic [DW-1:0] bus_s;
  logic [DW-1:0] addr_q;
  logic          wr_commit;
  logic          rd_done;
  logic          rd_live;
  logic [DW-1:0] rf_rdata;

  assign strb_raw = '{ale: ale, cs_n: cs_n, rd_n: rd_n, wr_n: wr_n};

  abus_sync #(.W(STRB_W), .STAGES(SYNC_STAGES), .RST_VAL(STROBE_IDLE)) u_strb_sync (
    .clk(clk), .rst_n(rst_n), .d(strb_raw), .q(strb_s)
  );

  // Bus value is delayed alongside the strobes so both are seen in the same cycle.
  abus_sync #(.W(DW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_bus_sync (
    .clk(clk), .rst_n(rst_n), .d(bus_in), .q(bus_s)
  );

  abus_cycle_ctl #(.DW(DW), .NUM_REGS(NUM_REGS)) u_ctl (
    .clk(clk), .rst_n(rst_n), .strb(strb_s), .bus_d(bus_s),
    .addr_q(addr_q), .wr_commit(wr_commit), .rd_done(rd_done), .rd_live(rd_live)
  );

  abus_regfile #(.DW(DW), .NUM_REGS(NUM_REGS)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(wr_commit), .waddr(addr_q), .wdata(bus_s),
    .raddr(addr_q), .rdata(rf_rdata), .regs_flat(regs_flat)
  );

  logic          oe_d;
  logic [DW-1:0] dout_d;
  logic          wp_d;
  logic [DW-1:0] wa_d;
  logic [DW-1:0] wd_d;
  logic          re_d;
  logic [DW-1:0] ra_d;

  always_comb begin
    oe_d   = rd_live;
    dout_d = rd_live ? rf_rdata : '0;
    wp_d   = wr_commit;
    wa_d   = wr_commit ? addr_q : wr_addr;
    wd_d   = wr_commit ? bus_s  : wr_data;
    re_d   = rd_done;
    ra_d   = rd_done ? addr_q : rd_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_oe   <= 1'b0;
      bus_out  <= '0;
      wr_pulse <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      rd_event <= 1'b0;
      rd_addr  <= '0;
    end else begin
      bus_oe   <= oe_d;
      bus_out  <= dout_d;
      wr_pulse <= wp_d;
      wr_addr  <= wa_d;
      wr_data  <= wd_d;
      rd_event <= re_d;
      rd_addr  <= ra_d;
    end
  end

endmodule

// File: rtl/abus_reg_slave_chk.sv
module abus_reg_slave_chk #(
  parameter int DW = 8,
  parameter int NUM_REGS = 6
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_oe,
  input logic [DW-1:0]          bus_out,
  input logic                   wr_pulse,
  input logic [DW-1:0]          wr_addr,
  input logic [DW-1:0]          wr_data,
  input logic                   rd_event,
  input logic                   rd_live,
  input logic [NUM_REGS*DW-1:0] regs_flat
);

  localparam logic [DW:0] ADDR_LIMIT = (DW+1)'(NUM_REGS);

  logic [DW-1:0] slot_val;
  always_comb begin
    slot_val = '0;
    for (int r = 0; r < NUM_REGS; r++) begin
      if (wr_addr == DW'(r)) slot_val = regs_flat[r*DW +: DW];
    end
  end

  // R5
  oe_tracks_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe == $past(rd_live));

  // R5
  released_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe |-> bus_out == '0);

  // R3
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |-> slot_val == wr_data);

  // R7
  wr_addr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |-> ({1'b0, wr_addr} < ADDR_LIMIT));

  // R8
  wr_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> !wr_pulse);

  // R9
  rd_event_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_event |=> !rd_event);

endmodule

bind abus_reg_slave abus_reg_slave_chk #(.DW(DW), .NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_oe(bus_oe), .bus_out(bus_out),
  .wr_pulse(wr_pulse), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_event(rd_event), .rd_live(rd_live), .regs_flat(regs_flat)
);

// File: tb/sim_abus_reg_slave.sv
module sim_abus_reg_slave;

  localparam int DW = 8;
  localparam int NR = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic ale, cs_n, rd_n, wr_n;
  logic [DW-1:0] bus_in;
  logic [DW-1:0] bus_out;
  logic bus_oe, wr_pulse, rd_event;
  logic [DW-1:0] wr_addr, wr_data, rd_addr;
  logic [NR*DW-1:0] regs_flat;

  always #5 clk = ~clk;

  abus_reg_slave #(.DW(DW), .NUM_REGS(NR), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .ale(ale), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
    .wr_pulse(wr_pulse), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_event(rd_event), .rd_addr(rd_addr), .regs_flat(regs_flat)
  );

  int n_chk = 0;
  int n_fail = 0;
  int wr_cnt = 0, rd_cnt = 0, wr_wide = 0, rd_wide = 0;
  logic [DW-1:0] last_wa, last_wd, last_ra;
  logic wp_prev = 1'b0, re_prev = 1'b0;
  logic [DW-1:0] model [NR];

  // Pulse monitor, sampled away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_pulse) begin wr_cnt++; last_wa = wr_addr; last_wd = wr_data; end
      if (rd_event) begin rd_cnt++; last_ra = rd_addr; end
      if (wr_pulse && wp_prev) wr_wide++;
      if (rd_event && re_prev) rd_wide++;
      wp_prev = wr_pulse;
      re_prev = rd_event;
    end
  end

  task automatic check_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [NR*DW-1:0] model_flat();
    logic [NR*DW-1:0] f;
    for (int r = 0; r < NR; r++) f[r*DW +: DW] = model[r];
    return f;
  endfunction

  task automatic put_addr(input logic [DW-1:0] a);
    @(negedge clk); bus_in = a; ale = 1'b1;
    repeat (2) @(negedge clk);
    ale = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic data_write(input logic [DW-1:0] d, input bit sel);
    bus_in = d; cs_n = !sel;
    @(negedge clk); wr_n = 1'b0;
    repeat (4) @(negedge clk); wr_n = 1'b1;
    repeat (4) @(negedge clk); cs_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic bus_write(input logic [DW-1:0] a, input logic [DW-1:0] d);
    put_addr(a);
    data_write(d, 1'b1);
  endtask

  task automatic bus_read(input logic [DW-1:0] a, output logic [DW-1:0] d, output logic oe);
    put_addr(a);
    bus_in = 8'h5A; cs_n = 1'b0;
    @(negedge clk); rd_n = 1'b0;
    repeat (5) @(negedge clk);
    d = bus_out; oe = bus_oe;
    rd_n = 1'b1;
    repeat (4) @(negedge clk); cs_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    check_eq("R1 bus_oe after reset", bus_oe, 0);
    check_eq("R1 bus_out after reset", bus_out, 0);
    check_eq("R1 regs after reset", regs_flat, 0);
    check_eq("R1 no pulses after reset", wr_pulse | rd_event, 0);
  endtask

  task automatic t_basic();
    logic [DW-1:0] d;
    logic oe;
    int w0, r0;
    for (int i = 0; i < NR; i++) begin
      w0 = wr_cnt;
      model[i] = 8'h11 * (i + 1);
      bus_write(DW'(i), model[i]);
      check_eq("R8 one write pulse", wr_cnt - w0, 1);
      check_eq("R8 pulse address", last_wa, DW'(i));
      check_eq("R8 pulse data", last_wd, model[i]);
    end
    check_eq("R8 write pulse width", wr_wide, 0);
    check_eq("R10 flat register view", regs_flat, model_flat());
    for (int i = NR - 1; i >= 0; i--) begin
      r0 = rd_cnt;
      bus_read(DW'(i), d, oe);
      check_eq("R6 read data", d, model[i]);
      check_eq("R5 oe during read", oe, 1);
      check_eq("R5 oe released after read", bus_oe, 0);
      check_eq("R9 one read event", rd_cnt - r0, 1);
      check_eq("R9 read event address", last_ra, DW'(i));
    end
    check_eq("R9 read event width", rd_wide, 0);
  endtask

  task automatic t_addr_hold();
    logic [DW-1:0] d;
    logic oe;
    put_addr(8'h03);
    bus_in = 8'h05;
    repeat (6) @(negedge clk);
    model[3] = 8'hC3;
    data_write(8'hC3, 1'b1);
    check_eq("R2 addr kept after bus change", regs_flat, model_flat());
    bus_read(8'h03, d, oe);
    check_eq("R2 read back latched addr", d, 8'hC3);
  endtask

  task automatic t_late_data();
    put_addr(8'h01);
    bus_in = 8'h10; cs_n = 1'b0;
    @(negedge clk); wr_n = 1'b0;
    repeat (3) @(negedge clk); bus_in = 8'h2F;
    repeat (4) @(negedge clk); wr_n = 1'b1;
    repeat (4) @(negedge clk); cs_n = 1'b1;
    repeat (3) @(negedge clk);
    model[1] = 8'h2F;
    check_eq("R3 value at write rise kept", regs_flat[1*DW +: DW], 8'h2F);
    check_eq("R3 last pulse data", last_wd, 8'h2F);
  endtask

  task automatic t_cs_gate();
    int w0;
    w0 = wr_cnt;
    put_addr(8'h02);
    data_write(8'hEE, 1'b0);
    check_eq("R4 no pulse without select", wr_cnt - w0, 0);
    check_eq("R4 registers unchanged", regs_flat, model_flat());
    put_addr(8'h02);
    @(negedge clk); rd_n = 1'b0;
    repeat (5) @(negedge clk);
    check_eq("R5 no drive with read but no select", bus_oe, 0);
    check_eq("R5 bus_out zero when released", bus_out, 0);
    rd_n = 1'b1; cs_n = 1'b0;
    repeat (5) @(negedge clk);
    check_eq("R5 no drive with select but no read", bus_oe, 0);
    cs_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_unimpl();
    logic [DW-1:0] d;
    logic oe;
    int w0, r0;
    w0 = wr_cnt;
    bus_write(8'h06, 8'hA6);
    bus_write(8'hFF, 8'hAF);
    check_eq("R7 no pulse for unimplemented", wr_cnt - w0, 0);
    check_eq("R7 registers unchanged", regs_flat, model_flat());
    r0 = rd_cnt;
    bus_read(8'h07, d, oe);
    check_eq("R7 unimplemented reads zero", d, 0);
    check_eq("R5 oe for unimplemented read", oe, 1);
    check_eq("R9 event for unimplemented read", rd_cnt - r0, 1);
    check_eq("R9 event addr unimplemented", last_ra, 8'h07);
  endtask

  initial begin
    rst_n = 1'b0; ale = 1'b0; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; bus_in = '0;
    for (int r = 0; r < NR; r++) model[r] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_basic();
    t_addr_hold();
    t_late_data();
    t_cs_gate();
    t_unimpl();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule